// File: doc/BRIEF.md
# Video timing-word sync normalizer

This block sits on the parallel side of a video serializer, in front of the scrambler. On every rising edge of the parallel clock it registers a 10-bit video word. A second register stage passes the word to the output. Between the two stages, the word is checked for the reserved timing-reference codes. A reserved word has its upper eight bits all zero or all one. When detection is enabled, the two least significant bits of such a word are overwritten to match the upper bits.

With this mapping, a source that drives only the upper eight lines with 8-bit sync codes (00 or FF) still produces the proper 10-bit sync words 000 and 3FF. Any 10-bit value from 000 to 003 becomes 000, and any value from 3FC to 3FF becomes 3FF. A detect-off input turns the mapping off for parallel data that is not video. In that mode every word passes through unchanged. This control is sampled on the same clock edge as the data word it applies to.

Alongside each output word the block gives a one-cycle marker. The marker is high when that word was recognised as a reserved code.

Top module: `vsn_sync_normalizer`

## Requirements
- R1: A synchronous active-high reset drives the output word to 000 and the marker low. Both stay there until the first word sampled after reset reaches the output.
- R2: Each word sampled at a rising clock edge appears on the output word two rising edges later. The detect-off level sampled at the same edge is applied to that word.
- R3: With detection enabled, a word whose bits 9..2 are all zero leaves as 000, whatever bits 1..0 held.
- R4: With detection enabled, a word whose bits 9..2 are all one leaves as 3FF, whatever bits 1..0 held.
- R5: A word whose bits 9..2 are neither all zero nor all one leaves unchanged and with the marker low, whatever the detect-off level.
- R6: With detect-off high, every word leaves unchanged, including 001, 002, 3FD and 3FE, and the marker stays low.
- R7: The marker is high for exactly one cycle, in the cycle where a mapped reserved word (000 or 3FF) is on the output. This also holds when that word already had its final low bits.
- R8: Detect-off may change on every cycle. Each word is treated by the level captured together with it, not by the level of a neighbouring cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| det_off_i | input | 1 | High: reserved-code detection off, words pass unchanged |
| din_i | input | 10 | Parallel video word, bit 9 the MSB |
| dout_o | output | 10 | Registered, normalized video word |
| rsv_hit_o | output | 1 | High in the cycle a mapped reserved word is on dout_o |

## Verification
Some properties are checked on every cycle by assertions beside the logic:
- the input stage capturing word and control together;
- the forced results for all-zero and all-one upper bits;
- untouched pass-through of ordinary words and of words with detection off;
- the marker appearing only with 000 or 3FF on the output;
- the quiet output before the first valid word.

The bench has to show the rest with its scenarios:
- the exact two-edge latency;
- all eight reserved inputs under both control levels;
- detect-off toggling word by word;
- a reset landing in the middle of a stream, including the words already in flight being discarded.

// File: rtl/vsn_pkg.sv
package vsn_pkg;

    localparam int WORD_W = 10;
    localparam int LOW_W  = 2;
    localparam int HIGH_W = WORD_W - LOW_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HIGH_W-1:0] high_t;
    typedef logic [LOW_W-1:0]  low_t;

    typedef enum logic [1:0] {
        CLS_DATA     = 2'd0,
        CLS_RSV_ZERO = 2'd1,
        CLS_RSV_ONES = 2'd2
    } rsv_cls_e;

    typedef struct packed {
        logic  valid;
        logic  det_off;
        word_t word;
    } lat_s;

    function automatic high_t upper_of(word_t w);
        return w[WORD_W-1:LOW_W];
    endfunction

    function automatic rsv_cls_e classify(word_t w);
        high_t u;
        u = upper_of(w);
        if (u == '0)      return CLS_RSV_ZERO;
        else if (&u)      return CLS_RSV_ONES;
        else              return CLS_DATA;
    endfunction

    function automatic word_t force_low(word_t w, rsv_cls_e c);
        word_t r;
        r = w;
        case (c)
            CLS_RSV_ZERO: r[LOW_W-1:0] = '0;
            CLS_RSV_ONES: r[LOW_W-1:0] = '1;
            default:      r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vsn_word_latch.sv
module vsn_word_latch
    import vsn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  det_off_i,
    input  word_t din_i,
    output lat_s  lat_o
);

    lat_s lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '{valid: 1'b0, det_off: 1'b1, word: '0};
        end else begin
            lat_q <= '{valid: 1'b1, det_off: det_off_i, word: din_i};
        end
    end

    assign lat_o = lat_q;

    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lat_q.valid && lat_q.word == $past(din_i)
                  && lat_q.det_off == $past(det_off_i))); // R2

endmodule

// File: rtl/vsn_rsv_classify.sv
module vsn_rsv_classify
    import vsn_pkg::*;
(
    input  lat_s     lat_i,
    output rsv_cls_e cls_o
);

    always_comb begin
        if (!lat_i.valid || lat_i.det_off) cls_o = CLS_DATA;
        else                               cls_o = classify(lat_i.word);
    end

endmodule

// File: rtl/vsn_low_force.sv
module vsn_low_force
    import vsn_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lat_s     lat_i,
    input  rsv_cls_e cls_i,
    output word_t    dout_o,
    output logic     hit_o
);

    word_t dout_q;
    logic  hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            hit_q  <= 1'b0;
        end else begin
            dout_q <= lat_i.valid ? force_low(lat_i.word, cls_i) : '0;
            hit_q  <= (cls_i != CLS_DATA);
        end
    end

    assign dout_o = dout_q;
    assign hit_o  = hit_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lat_i.valid |=> (dout_q == '0 && !hit_q)); // R1

    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (rst)
        (lat_i.valid && !lat_i.det_off && lat_i.word[WORD_W-1:LOW_W] == '0)
        |=> (dout_q == '0 && hit_q)); // R3

    AST_ONES_MAP: assert property (@(posedge clk) disable iff (rst)
        (lat_i.valid && !lat_i.det_off && &lat_i.word[WORD_W-1:LOW_W])
        |=> (dout_q == '1 && hit_q)); // R4

    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (rst)
        (lat_i.valid && cls_i == CLS_DATA)
        |=> (dout_q == $past(lat_i.word) && !hit_q)); // R5

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (lat_i.valid && lat_i.det_off)
        |=> (dout_q == $past(lat_i.word) && !hit_q)); // R6

    AST_HIT_CODE: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> (dout_q == '0 || dout_q == '1)); // R7

endmodule

// File: rtl/vsn_sync_normalizer.sv
module vsn_sync_normalizer
    import vsn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              det_off_i,
    input  logic [WORD_W-1:0] din_i,
    output logic [WORD_W-1:0] dout_o,
    output logic              rsv_hit_o
);

    lat_s     lat;
    rsv_cls_e cls;

    vsn_word_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .det_off_i (det_off_i),
        .din_i     (din_i),
        .lat_o     (lat)
    );

    vsn_rsv_classify u_classify (
        .lat_i (lat),
        .cls_o (cls)
    );

    vsn_low_force u_force (
        .clk    (clk),
        .rst    (rst),
        .lat_i  (lat),
        .cls_i  (cls),
        .dout_o (dout_o),
        .hit_o  (rsv_hit_o)
    );

endmodule

// File: tb/vsn_sync_normalizer_bench.sv
module vsn_sync_normalizer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       det_off = 1'b0;
    logic [9:0] din = '0;
    logic [9:0] dout;
    logic       hit;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench-side model of the two register stages
    bit       s1_v = 0, s1_off = 0, s2_v = 0, s2_off = 0;
    bit [9:0] s1_w = '0, s2_w = '0;

    always #5 clk = ~clk;

    vsn_sync_normalizer u_vsn_sync_normalizer (
        .clk       (clk),
        .rst       (rst),
        .det_off_i (det_off),
        .din_i     (din),
        .dout_o    (dout),
        .rsv_hit_o (hit)
    );

    function automatic bit [9:0] exp_word(bit v, bit off, bit [9:0] w);
        if (!v)                 return 10'h000;
        if (off)                return w;
        if (w[9:2] == 8'h00)    return 10'h000;
        if (w[9:2] == 8'hFF)    return 10'h3FF;
        return w;
    endfunction

    function automatic bit exp_hit(bit v, bit off, bit [9:0] w);
        return v && !off && (w[9:2] == 8'h00 || w[9:2] == 8'hFF);
    endfunction

    function automatic string req_of(bit v, bit off, bit [9:0] w);
        if (!v)                 return "R1";
        if (off)                return "R6/R8";
        if (w[9:2] == 8'h00)    return "R3";
        if (w[9:2] == 8'hFF)    return "R4";
        return "R5/R2";
    endfunction

    // called at the falling edge: advance model by the rising edge just passed,
    // compare, then drive the next inputs
    task automatic step(bit r, bit off, bit [9:0] w);
        bit [9:0] ew;
        bit       eh;
        if (rst) begin
            s1_v = 0; s2_v = 0;
        end else begin
            s2_v = s1_v; s2_off = s1_off; s2_w = s1_w;
            s1_v = 1;    s1_off = det_off; s1_w = din;
        end
        ew = exp_word(s2_v, s2_off, s2_w);
        eh = exp_hit(s2_v, s2_off, s2_w);
        n_vec++;
        if (dout !== ew) begin
            n_fail++;
            $display("FAIL %s word: actual %h expected %h", req_of(s2_v, s2_off, s2_w), dout, ew);
        end
        n_vec++;
        if (hit !== eh) begin
            n_fail++;
            $display("FAIL R7 marker: actual %b expected %b (word %h)", hit, eh, s2_w);
        end
        rst = r; det_off = off; din = w;
    endtask

    initial begin
        void'($urandom(32'h5EED_0A1D));
        // R1: reset state
        repeat (3) begin @(negedge clk); step(1, 0, 10'h155); end
        @(negedge clk); step(0, 0, 10'h2AA);
        // R3 / R4 / R7: all reserved inputs with detection on
        for (int i = 0; i < 4; i++) begin @(negedge clk); step(0, 0, 10'(i)); end
        for (int i = 0; i < 4; i++) begin @(negedge clk); step(0, 0, 10'h3FC + 10'(i)); end
        // R6: same inputs with detection off
        for (int i = 0; i < 4; i++) begin @(negedge clk); step(0, 1, 10'(i)); end
        for (int i = 0; i < 4; i++) begin @(negedge clk); step(0, 1, 10'h3FC + 10'(i)); end
        // R5: near-reserved ordinary words
        @(negedge clk); step(0, 0, 10'h004);
        @(negedge clk); step(0, 0, 10'h3FB);
        @(negedge clk); step(0, 0, 10'h201);
        @(negedge clk); step(0, 0, 10'h1FE);
        // R8: detect-off alternating word by word on reserved inputs
        for (int i = 0; i < 8; i++) begin @(negedge clk); step(0, i[0], (i[1]) ? 10'h3FD : 10'h002); end
        // R1: reset in mid-stream discards words in flight
        @(negedge clk); step(0, 0, 10'h001);
        @(negedge clk); step(1, 0, 10'h3FE);
        @(negedge clk); step(0, 0, 10'h3FE);
        @(negedge clk); step(0, 0, 10'h0F0);
        // random mix, biased towards reserved codes
        for (int i = 0; i < 3000; i++) begin
            bit [9:0] w;
            int sel;
            sel = $urandom_range(0, 3);
            w = 10'($urandom());
            if (sel == 0) w[9:2] = 8'h00;
            else if (sel == 1) w[9:2] = 8'hFF;
            @(negedge clk);
            step(($urandom_range(0, 199) == 0), ($urandom_range(0, 3) == 0), w);
        end
        repeat (3) begin @(negedge clk); step(0, 0, 10'h000); end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule